// File: doc/BRIEF.md
# Multi-Channel ADC Threshold Monitor

This block watches up to eight logical channels of an external analog-to-digital converter. Each channel is configured through a byte-wide register port. The configuration chooses which converter input to sample, a 16-bit low bound and a 16-bit high bound, a periodic timer, a settle delay and the interrupt enables. Once monitoring is started, every timer expiry marks the channels tied to that timer as due. A round-robin arbiter then services the due channels, one conversion at a time, over a request/valid handshake.

A returned code below a channel's low bound sets that channel's bit in a sticky low-status register. A code above the high bound sets its bit in a sticky high-status register. A single interrupt line reports the status bits whose channel and bound are enabled. The block's clock is divided to a tick, and the tick drives the timer periods. The settle delays are counted in clocks. Both are parameters, so the same logic runs at full scale on silicon or shortened in a testbench. The calibration select field is stored and read back only.

Top module: `adc_thresh_mon`

## Requirements
- R1: After reset both status registers (0x0a low, 0x0b high) read 0, `adc_req` and `irq` are low, and address 0x0f reads the channel count 8.
- R2: Channel n owns the bytes 0x60+8n to 0x67+8n, and each byte reads back as written. The bytes are: +0 converter input (driven on `adc_sel`), +1/+2 low bound (low byte first), +3/+4 high bound (low byte first), +5 timer select, +6 control, +7 enable.
- R3: No conversion is requested until bit 7 of 0x46 (global enable) and bit 7 of 0x47 (conversion request) are both set.
- R4: When bit 7 of a channel's enable byte is set, a returned code strictly below the low bound sets bit n of 0x0a, and a code strictly above the high bound sets bit n of 0x0b. A code equal to a bound sets nothing.
- R5: Status bits stay set until a write of 1 to that bit position. Writing 0 has no effect. A new event in the same cycle as a clearing write leaves the bit set.
- R6: `irq` is the OR, over the channels whose enable bit 7 is set, of (low status AND enable bit 0) OR (high status AND enable bit 1).
- R7: Timer select (byte +5, bits 1:0) picks the sampling period. 0 gives P1_TICKS ticks, 1 gives P2_TICKS, 2 gives P3_TICKS, and 3 means the channel is never sampled.
- R8: Channels that are due together are served round-robin, starting after the channel served last.
- R9: Control bits 3:0 are a settle index N. The request for a channel rises N*SETTLE_UNIT+3 clocks after the previous conversion's `adc_valid`, when that channel is already waiting.
- R10: Clearing a channel's enable bit 7 stops new requests for it, discards any result still in flight, and keeps its latched status bits.
- R11: `adc_req` stays high with `adc_sel` stable until `adc_valid`, and drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| adc_req | output | 1 | Conversion request |
| adc_sel | output | 8 | Converter input to sample |
| adc_valid | input | 1 | Conversion result valid |
| adc_code | input | 16 | Conversion result code |
| irq | output | 1 | Threshold interrupt |

## Verification
A software write that clears a status bit can land in the same cycle as a conversion result that sets that bit. The bench provokes this by waiting for the converter stub to raise `adc_valid` on an out-of-range code, and then issuing the clear write at once so that both are sampled at the same edge. The status register is read one cycle later, before any further conversion can arrive. It must still show the bit set. Separately, timer expiries that make all channels due at the same tick are checked through the order of `adc_sel` values, which must step through the channels in sequence.

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon #(
  parameter int NCH         = 8,
  parameter int TICK_DIV    = 50,
  parameter int P1_TICKS    = 3900,
  parameter int P2_TICKS    = 1000000,
  parameter int P3_TICKS    = 4000000,
  parameter int SETTLE_UNIT = 64,
  parameter int TW          = 24,
  parameter int SW          = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        adc_req,
  output logic [7:0]  adc_sel,
  input  logic        adc_valid,
  input  logic [15:0] adc_code,
  output logic        irq
);
  localparam int IW = $clog2(NCH);
  localparam logic [7:0] WIN = 8'h60;
  localparam logic [TW-1:0] TD_M1 = TW'(TICK_DIV - 1);
  localparam logic [TW-1:0] PER [3] = '{TW'(P1_TICKS - 1), TW'(P2_TICKS - 1), TW'(P3_TICKS - 1)};

  typedef enum logic [1:0] {S_IDLE, S_SET, S_REQ} st_t;

  logic [7:0] creg [NCH][8];
  logic gen_en, conv_go;
  logic [NCH-1:0] slo, shi, pend, meas, lie, hie, due, gmask, set_lo, set_hi, clr_lo, clr_hi;
  logic [TW-1:0] pcnt;
  logic [TW-1:0] tmr [3];
  logic [3:0] fire;
  logic tick, found;
  st_t state;
  logic [IW-1:0] cur, nxt;
  logic [SW-1:0] scnt;
  logic [7:0] off;
  logic in_win;
  logic [IW-1:0] wch;
  logic [15:0] cur_lo, cur_hi;

  wire running = gen_en & conv_go;
  assign off    = reg_addr - WIN;
  assign in_win = (reg_addr >= WIN) && (int'(off) < 8 * NCH);
  assign wch    = off[IW+2:3];
  assign tick   = (pcnt == TD_M1);
  assign cur_lo = {creg[cur][2], creg[cur][1]};
  assign cur_hi = {creg[cur][4], creg[cur][3]};

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      meas[n] = creg[n][7][7];
      hie[n]  = creg[n][7][1];
      lie[n]  = creg[n][7][0];
    end
    for (int k = 0; k < 3; k++) fire[k] = tick && (tmr[k] == PER[k]);
    fire[3] = 1'b0;
    for (int n = 0; n < NCH; n++)
      due[n] = running && meas[n] && (creg[n][5][1:0] != 2'd3) && fire[creg[n][5][1:0]];
    found = 1'b0;
    nxt   = cur;
    for (int j = 1; j <= NCH; j++) begin
      int k;
      k = (int'(cur) + j) % NCH;
      if (!found && pend[k]) begin
        found = 1'b1;
        nxt   = IW'(k);
      end
    end
    gmask = '0;
    if (state == S_IDLE && running && found) gmask[nxt] = 1'b1;
    set_lo = '0;
    set_hi = '0;
    if (state == S_REQ && adc_valid && meas[cur]) begin
      set_lo[cur] = adc_code < cur_lo;
      set_hi[cur] = adc_code > cur_hi;
    end
    clr_lo = (reg_we && reg_addr == 8'h0a) ? reg_wdata[NCH-1:0] : '0;
    clr_hi = (reg_we && reg_addr == 8'h0b) ? reg_wdata[NCH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++)
        for (int b = 0; b < 8; b++) creg[n][b] <= '0;
      gen_en  <= 1'b0;
      conv_go <= 1'b0;
    end else if (reg_we) begin
      if (in_win) creg[wch][off[2:0]] <= reg_wdata;
      if (reg_addr == 8'h46) gen_en  <= reg_wdata[7];
      if (reg_addr == 8'h47) conv_go <= reg_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      for (int k = 0; k < 3; k++) tmr[k] <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick)
        for (int k = 0; k < 3; k++) tmr[k] <= fire[k] ? '0 : tmr[k] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= IW'(NCH - 1);
      scnt  <= '0;
      pend  <= '0;
      slo   <= '0;
      shi   <= '0;
    end else begin
      pend <= (pend | due) & meas & ~gmask;
      slo  <= (slo & ~clr_lo) | set_lo;
      shi  <= (shi & ~clr_hi) | set_hi;
      case (state)
        S_IDLE: if (running && found) begin
          cur   <= nxt;
          scnt  <= SW'(creg[nxt][6][3:0]) * SW'(SETTLE_UNIT);
          state <= S_SET;
        end
        S_SET: if (scnt == '0) state <= S_REQ; else scnt <= scnt - 1'b1;
        S_REQ: if (adc_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adc_req = (state == S_REQ);
  assign adc_sel = creg[cur][0];
  assign irq     = |(((slo & lie) | (shi & hie)) & meas);

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      8'h0a: reg_rdata = 8'(slo);
      8'h0b: reg_rdata = 8'(shi);
      8'h0f: reg_rdata = 8'(NCH);
      8'h46: reg_rdata = {gen_en, 7'b0};
      8'h47: reg_rdata = {conv_go, 7'b0};
      default: if (in_win) reg_rdata = creg[wch][off[2:0]];
    endcase
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_valid) |=> (adc_req && $stable(adc_sel)));
  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && adc_valid) |=> !adc_req);
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((slo | shi) != '0));
  // R4
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slo & ~$past(slo)) != '0) |-> $past(adc_valid && adc_req));
  // R4
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((shi & ~$past(shi)) != '0) |-> $past(adc_valid && adc_req));
endmodule

// File: tb/adc_thresh_mon_tb.sv
module adc_thresh_mon_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata, adc_sel;
  logic adc_req, adc_valid = 0, irq;
  logic [15:0] adc_code = 0;

  localparam int SU = 2;
  adc_thresh_mon #(.NCH(8), .TICK_DIV(4), .P1_TICKS(5), .P2_TICKS(20), .P3_TICKS(40),
                   .SETTLE_UNIT(SU), .TW(16), .SW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .adc_req(adc_req), .adc_sel(adc_sel), .adc_valid(adc_valid),
    .adc_code(adc_code), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int reqcnt [8];
  int hist [64];
  int hn = 0, gn = 0, gmin = 0, gmax = 0, vcyc = 0;
  bit have_v = 0;
  logic [15:0] code_tab [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clr_stats();
    for (int i = 0; i < 8; i++) reqcnt[i] = 0;
    hn = 0; gn = 0; gmin = 1000; gmax = 0; have_v = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (adc_req) begin
        int s;
        s = int'(adc_sel[2:0]);
        reqcnt[s]++;
        if (hn < 64) begin hist[hn] = s; hn++; end
        if (have_v) begin
          int g;
          g = cyc - vcyc;
          gn++;
          if (gn > 2) begin
            if (g < gmin) gmin = g;
            if (g > gmax) gmax = g;
          end
        end
        @(negedge clk); @(negedge clk);
        adc_code = code_tab[s];
        adc_valid = 1;
        vcyc = cyc; have_v = 1;
        @(negedge clk);
        adc_valid = 0;
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cfg(int n, logic [7:0] sel, logic [15:0] lo, logic [15:0] hi,
                     logic [7:0] ts, logic [7:0] ctl, logic [7:0] en);
    logic [7:0] b;
    b = 8'(8'h60 + 8 * n);
    wr(b, sel); wr(b + 1, lo[7:0]); wr(b + 2, lo[15:8]);
    wr(b + 3, hi[7:0]); wr(b + 4, hi[15:8]); wr(b + 5, ts);
    wr(b + 6, ctl); wr(b + 7, en);
  endtask

  task automatic idle_all();
    wr(8'h46, 8'h00);
    for (int n = 0; n < 8; n++) wr(8'(8'h67 + 8 * n), 8'h00);
    repeat (60) @(negedge clk);
    wr(8'h0a, 8'hff); wr(8'h0b, 8'hff);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, slo_e, shi_e;
    int c0, c1, c2, c3, ok;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) code_tab[i] = 16'h8000;
    clr_stats();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h0a, d); chk("R1 lo status", d, 0);
    rd(8'h0b, d); chk("R1 hi status", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 adc_req", adc_req, 0);
    rd(8'h0f, d); chk("R1 channel count", d, 8);

    // R2 window readback
    cfg(5, 8'h33, 16'h1234, 16'hABCD, 8'h02, 8'h27, 8'h03);
    rd(8'h60 + 40 + 1, d); chk("R2 ch5 low lsb", d, 8'h34);
    rd(8'h60 + 40 + 4, d); chk("R2 ch5 high msb", d, 8'hAB);
    rd(8'h60 + 40 + 6, d); chk("R2 ch5 ctl", d, 8'h27);
    cfg(5, 0, 0, 0, 0, 0, 0);

    // R3 gating
    code_tab[0] = 16'h0800;
    cfg(0, 8'h00, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h83);
    wr(8'h46, 8'h80);
    repeat (300) @(negedge clk);
    chk("R3 no requests with only global enable", reqcnt[0], 0);
    rd(8'h0a, d); chk("R3 no status before start", d, 0);
    wr(8'h47, 8'h80);
    repeat (300) @(negedge clk);
    chk("R3 requests after start", int'(reqcnt[0] > 0), 1);
    // R4 low event
    rd(8'h0a, d); chk("R4 low event", d, 8'h01);
    rd(8'h0b, d); chk("R4 no high event", d, 8'h00);
    chk("R6 irq on low event", irq, 1);

    // R5 write-1-to-clear
    wr(8'h46, 8'h00);
    repeat (60) @(negedge clk);
    wr(8'h0a, 8'h00);
    rd(8'h0a, d); chk("R5 write 0 keeps", d, 8'h01);
    wr(8'h0a, 8'h01);
    rd(8'h0a, d); chk("R5 write 1 clears", d, 8'h00);
    chk("R6 irq cleared", irq, 0);

    // R6 enable gating
    cfg(0, 8'h00, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h80);
    wr(8'h46, 8'h80);
    repeat (200) @(negedge clk);
    rd(8'h0a, d); chk("R4 status without irq enable", d, 8'h01);
    chk("R6 irq masked by low enable", irq, 0);
    wr(8'h67, 8'h81);
    @(negedge clk);
    chk("R6 irq with low enable", irq, 1);
    // R10 measurement disable
    wr(8'h67, 8'h01);
    repeat (20) @(negedge clk);
    c0 = reqcnt[0];
    repeat (300) @(negedge clk);
    chk("R10 no new requests", reqcnt[0], c0);
    rd(8'h0a, d); chk("R10 status kept", d, 8'h01);
    chk("R6 irq off for disabled channel", irq, 0);

    // R4 equality boundaries and high event
    idle_all();
    code_tab[0] = 16'h1000; code_tab[1] = 16'h2000; code_tab[2] = 16'h2001;
    cfg(0, 8'h00, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h83);
    cfg(1, 8'h01, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h83);
    cfg(2, 8'h02, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h82);
    wr(8'h46, 8'h80);
    repeat (300) @(negedge clk);
    rd(8'h0a, d); chk("R4 equal bounds no low event", d, 8'h00);
    rd(8'h0b, d); chk("R4 high event only above", d, 8'h04);
    chk("R6 irq on high event", irq, 1);

    // R7 timer selects
    idle_all();
    for (int i = 0; i < 8; i++) code_tab[i] = 16'h1800;
    cfg(0, 8'h00, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h80);
    cfg(1, 8'h01, 16'h1000, 16'h2000, 8'h02, 8'h00, 8'h80);
    cfg(2, 8'h02, 16'h1000, 16'h2000, 8'h03, 8'h00, 8'h80);
    cfg(3, 8'h03, 16'h1000, 16'h2000, 8'h01, 8'h00, 8'h80);
    clr_stats();
    wr(8'h46, 8'h80);
    repeat (1600) @(negedge clk);
    c0 = reqcnt[0]; c1 = reqcnt[1]; c2 = reqcnt[2]; c3 = reqcnt[3];
    chk("R7 select 3 never sampled", c2, 0);
    chk("R7 timer3 count", int'(c1 >= 8 && c1 <= 11), 1);
    chk("R7 timer2 count", int'(c3 >= 17 && c3 <= 21), 1);
    chk("R7 timer1 count", int'(c0 >= 60 && c0 <= 85), 1);

    // R8 round robin, R9 settle
    idle_all();
    for (int n = 0; n < 8; n++) cfg(n, 8'(n), 16'h1000, 16'h2000, 8'h00, 8'h03, 8'h80);
    clr_stats();
    wr(8'h46, 8'h80);
    repeat (600) @(negedge clk);
    ok = 1;
    for (int i = 1; i < 16; i++) if (hist[i] != (hist[i-1] + 1) % 8) ok = 0;
    chk("R8 round-robin order", ok, 1);
    chk("R9 settle gap min", gmin, 3 * SU + 3);
    chk("R9 settle gap max", gmax, 3 * SU + 3);

    // R5 clear and set in the same cycle
    idle_all();
    code_tab[0] = 16'h0100;
    cfg(0, 8'h00, 16'h1000, 16'h2000, 8'h00, 8'h00, 8'h80);
    wr(8'h46, 8'h80);
    @(posedge adc_valid);
    reg_addr = 8'h0a; reg_wdata = 8'h01; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    #1 chk("R5 set wins over clear", reg_rdata, 8'h01);

    // R4 R6 random rounds
    for (int r = 0; r < 6; r++) begin
      logic [7:0] sel [8], en [8];
      logic [15:0] lo [8], hi [8];
      logic ie;
      idle_all();
      for (int i = 0; i < 8; i++) code_tab[i] = 16'($urandom);
      slo_e = 0; shi_e = 0; ie = 0;
      for (int n = 0; n < 8; n++) begin
        sel[n] = 8'($urandom_range(0, 7));
        lo[n] = 16'($urandom); hi[n] = 16'($urandom);
        en[n] = {$urandom_range(0, 3) != 0, 5'b0, 1'($urandom), 1'($urandom)};
        cfg(n, sel[n], lo[n], hi[n], 8'h00, 8'h00, en[n]);
        if (en[n][7]) begin
          slo_e[n] = code_tab[sel[n][2:0]] < lo[n];
          shi_e[n] = code_tab[sel[n][2:0]] > hi[n];
          ie = ie | (slo_e[n] & en[n][0]) | (shi_e[n] & en[n][1]);
        end
      end
      wr(8'h46, 8'h80);
      repeat (600) @(negedge clk);
      rd(8'h0a, d); chk("R4 random low status", d, slo_e);
      rd(8'h0b, d); chk("R4 random high status", d, shi_e);
      chk("R6 random irq", irq, ie);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule